// File: doc/BRIEF.md
# ULPI PHY-Side Pin Guard

This block sits on the PHY side of a ULPI link. It decides how the PHY's interface pins behave in three situations: while the PHY is held in reset, while the chip is deselected, and while the link side seems to be undriven. It drives DIR high for the whole reset period and for a fixed number of clock cycles afterwards. It turns off every PHY output driver while chip select is inactive, and it hides STP from the rest of the PHY during that time. When STP is seen high at a point where no legitimate stop can occur, it requests weak pull-downs on the DATA bus.

The PHY core supplies two inputs. The first is the DIR level it would drive on its own. The second is a flag that is high while a link-to-PHY transmit is in progress. The guard merges these with its reset and deselect rules. It returns the final DIR level, the output enables for DATA, NXT and DIR, the DATA pull-down request, a masked copy of STP, and a PLL power request. The PLL request stays off after a power-up with chip select inactive. It turns on at the first selection and then stays on until the next reset.

Top module: `ulpi_pin_guard`

## Requirements
- R1: While `rstN` is low, `dirOut` is 1 (asserted asynchronously, with no clock edge needed), `dataPullDn` is 0 and `dataOe` is 0.
- R2: After `rstN` rises between clock edges, `dirOut` stays 1 through the fifth rising edge that follows. It falls to the `phyDirReq` level after the sixth edge. This is two synchronizer edges plus a four-edge hold count.
- R3: Once the hold count is over, `dirOut` equals `phyDirReq`. `dataOe` is 1 exactly when the chip is selected and `phyDirReq` is 1.
- R4: While the chip is deselected, `dirOe`, `nxtOe`, `dataOe` and `stpQual` are all 0, and STP has no effect on `dataPullDn` (it stays 0).
- R5: While the chip is selected, `dirOe` and `nxtOe` are 1 and `stpQual` equals `stpIn`.
- R6: If STP is high at a clock edge while selected, and the legitimate window is not open, `dataPullDn` is 1 after that edge. The legitimate window is open when `dirOut` is 0 and `linkTxBusy` is 1; inside it, a high STP leaves `dataPullDn` at 0.
- R7: If STP is low at a clock edge, `dataPullDn` is 0 after that edge.
- R8: While `protDis` is 1, `dataPullDn` is 0 in the same cycle, whatever the STP level. After reset, protection is enabled whenever `protDis` is 0.
- R9: `pllPwrReq` is 1 while the synchronized chip select is active. After the chip has been selected once since reset, `pllPwrReq` stays 1 regardless of chip select. A reset taken while deselected brings it back to 0.
- R10: A change on `csN` reaches the output enables after the second rising edge. After the first edge the enables still show the old selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| stpIn | input | 1 | STP pin level from the link |
| linkTxBusy | input | 1 | PHY core flag: link-to-PHY transmit in progress |
| phyDirReq | input | 1 | DIR level requested by the PHY core |
| protDis | input | 1 | Register bit: 1 disables the DATA pull-down protection |
| dirOut | output | 1 | Value for the DIR pin |
| dirOe | output | 1 | Output enable for DIR |
| nxtOe | output | 1 | Output enable for NXT |
| dataOe | output | 1 | Output enable for DATA[7:0] |
| dataPullDn | output | 1 | Weak pull-down enable for DATA[7:0] |
| stpQual | output | 1 | STP masked by chip select, toward the PHY core |
| pllPwrReq | output | 1 | PLL power request |

## Verification
The protection detector is driven with every combination that matters: STP high and low, transmit-busy set and clear, PHY DIR high and low, and the disable bit set and clear. These cases separate a real stop from a stray one: a high STP counts only when DIR is low and a transmit is running. They also show that the disable bit beats the detector. Directed sequences release reset between edges and count the edges until DIR falls, which separates the synchronizer delay from the hold count. They toggle chip select to show the two-edge latency, the STP masking and the driver shutdown. They also run two power-ups, one selected and one deselected, to separate the cases where the PLL request is off, following chip select, and latched on.

// File: rtl/ulpi_guard_pkg.sv
package ulpi_guard_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic holding;     // reset or post-reset DIR hold in force
    logic csActive;    // synchronized chip select, 1 = selected
    logic pllLatched;  // chip has been selected since reset
  } guard_strobe_t;
endpackage

// File: rtl/ulpi_guard_ctrl.sv
module ulpi_guard_ctrl
  import ulpi_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  output guard_strobe_t strobes
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] rstPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [CNT_W-1:0]       holdCnt;
  logic                   pllSeen;
  logic                   rstRel;
  logic                   csActive;

  // Reset release synchronizer: asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= '0;
    else       rstPipe <= {rstPipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstRel = rstPipe[SYNC_STAGES-1];

  // Chip select synchronizer keeps running through reset, so that
  // deselection still reaches the drivers while reset is held.
  always_ff @(posedge clk) begin
    csPipe <= {csPipe[SYNC_STAGES-2:0], ~csN};
  end
  assign csActive = csPipe[SYNC_STAGES-1];

  // Post-release DIR hold counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            holdCnt <= '0;
    else if (rstRel && holdCnt != HOLD_END) holdCnt <= holdCnt + 1'b1;
  end

  // Sticky record that the chip has been selected since reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pllSeen <= 1'b0;
    else if (csActive) pllSeen <= 1'b1;
  end

  assign strobes.holding    = (holdCnt != HOLD_END);
  assign strobes.csActive   = csActive;
  assign strobes.pllLatched = pllSeen;
endmodule

// File: rtl/ulpi_guard_dp.sv
module ulpi_guard_dp
  import ulpi_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  guard_strobe_t strobes,
  input  logic          stpIn,
  input  logic          linkTxBusy,
  input  logic          phyDirReq,
  input  logic          protDis,
  output logic          dirOut,
  output logic          dirOe,
  output logic          nxtOe,
  output logic          dataOe,
  output logic          dataPullDn,
  output logic          stpQual,
  output logic          pllPwrReq
);
  logic protFlag;
  logic stpWindow;

  assign dirOut    = strobes.holding | phyDirReq;
  // STP is expected only while the link is transmitting to the PHY.
  assign stpWindow = ~dirOut & linkTxBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protFlag <= 1'b0;
    else       protFlag <= strobes.csActive & stpIn & ~stpWindow;
  end

  assign dirOe      = strobes.csActive;
  assign nxtOe      = strobes.csActive;
  assign dataOe     = strobes.csActive & ~strobes.holding & phyDirReq;
  assign dataPullDn = protFlag & ~protDis;
  assign stpQual    = strobes.csActive & stpIn;
  assign pllPwrReq  = strobes.pllLatched | strobes.csActive;
endmodule

// File: rtl/ulpi_pin_guard.sv
module ulpi_pin_guard
  import ulpi_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic stpIn,
  input  logic linkTxBusy,
  input  logic phyDirReq,
  input  logic protDis,
  output logic dirOut,
  output logic dirOe,
  output logic nxtOe,
  output logic dataOe,
  output logic dataPullDn,
  output logic stpQual,
  output logic pllPwrReq
);
  guard_strobe_t strobes;

  ulpi_guard_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .strobes(strobes)
  );

  ulpi_guard_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .stpIn     (stpIn),
    .linkTxBusy(linkTxBusy),
    .phyDirReq (phyDirReq),
    .protDis   (protDis),
    .dirOut    (dirOut),
    .dirOe     (dirOe),
    .nxtOe     (nxtOe),
    .dataOe    (dataOe),
    .dataPullDn(dataPullDn),
    .stpQual   (stpQual),
    .pllPwrReq (pllPwrReq)
  );
endmodule

// File: rtl/ulpi_guard_chk.sv
module ulpi_guard_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic stpIn,
  input logic linkTxBusy,
  input logic phyDirReq,
  input logic protDis,
  input logic dirOut,
  input logic dirOe,
  input logic nxtOe,
  input logic dataOe,
  input logic dataPullDn,
  input logic stpQual,
  input logic pllPwrReq
);
  // R1: DIR high during reset
  p_dir_in_reset_r1: assert property (@(posedge clk) !rstN |-> dirOut);

  // R2: DIR still high on the first edge after release
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> dirOut);

  // R3: DATA driven only while DIR is high and DIR is driven
  p_data_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dirOut && dirOe));

  // R4: two edges of deselect silence all drivers and STP
  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && $past(csN, 2)) |-> (!dirOe && !nxtOe && !dataOe && !stpQual));

  // R6: pull-downs only follow a high STP
  p_pulldown_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataPullDn |-> $past(stpIn));

  // R7: low STP clears the pull-downs
  p_stp_low_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stpIn) |-> !dataPullDn);

  // R8: the disable bit wins
  p_prot_dis_r8: assert property (@(posedge clk) disable iff (!rstN)
    protDis |-> !dataPullDn);

  // R9: PLL request is sticky outside reset
  p_pll_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(pllPwrReq)) |-> pllPwrReq);
endmodule

bind ulpi_pin_guard ulpi_guard_chk chk_i (.*);

// File: tb/ulpi_pin_guard_tb_top.sv
module ulpi_pin_guard_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0;
  logic stpIn = 1'b0;
  logic linkTxBusy = 1'b0;
  logic phyDirReq = 1'b0;
  logic protDis = 1'b0;
  logic dirOut, dirOe, nxtOe, dataOe, dataPullDn, stpQual, pllPwrReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ulpi_pin_guard dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .stpIn(stpIn),
    .linkTxBusy(linkTxBusy), .phyDirReq(phyDirReq), .protDis(protDis),
    .dirOut(dirOut), .dirOe(dirOe), .nxtOe(nxtOe), .dataOe(dataOe),
    .dataPullDn(dataPullDn), .stpQual(stpQual), .pllPwrReq(pllPwrReq)
  );

  // Row: {stp, txBusy, phyDir, protDis, expPullDn, expDirOut, expDataOe}
  localparam logic [6:0] VEC [8] = '{
    7'b0000_000,  // idle
    7'b1000_100,  // stray STP: R6
    7'b1100_000,  // legitimate stop window: R6
    7'b1110_111,  // STP while DIR high: R6, R3
    7'b1001_000,  // disable bit: R8
    7'b1000_100,  // protection back on: R8
    7'b0010_011,  // STP low clears: R7, R3
    7'b0100_000   // busy, STP low: R7
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state with chip selected
    edges(4);
    chk("R1", "dirOut in reset", dirOut, 1'b1);
    chk("R1", "dataPullDn in reset", dataPullDn, 1'b0);
    chk("R1", "dataOe in reset", dataOe, 1'b0);
    chk("R5", "dirOe selected", dirOe, 1'b1);
    chk("R9", "pll with cs low in reset", pllPwrReq, 1'b1);

    // Release between edges and count edges until DIR falls
    rstN = 1'b1;
    for (int e = 1; e <= 6; e++) begin
      edges(1);
      chk("R2", $sformatf("dirOut after edge %0d", e), dirOut, (e < 6));
    end

    // Vector table
    for (int v = 0; v < 8; v++) begin
      {stpIn, linkTxBusy, phyDirReq, protDis} = VEC[v][6:3];
      edges(1);
      chk("R6", $sformatf("vec %0d dataPullDn", v), dataPullDn, VEC[v][2]);
      chk("R3", $sformatf("vec %0d dirOut", v), dirOut, VEC[v][1]);
      chk("R3", $sformatf("vec %0d dataOe", v), dataOe, VEC[v][0]);
      chk("R5", $sformatf("vec %0d stpQual", v), stpQual, stpIn);
      chk("R5", $sformatf("vec %0d nxtOe", v), nxtOe, 1'b1);
    end

    // Disable bit acts in the same cycle
    stpIn = 1'b1; linkTxBusy = 1'b0; phyDirReq = 1'b0; protDis = 1'b0;
    edges(1);
    chk("R6", "pull-down before disable", dataPullDn, 1'b1);
    protDis = 1'b1;
    #1;
    chk("R8", "same-cycle disable", dataPullDn, 1'b0);
    protDis = 1'b0;
    stpIn = 1'b0;
    edges(1);

    // Deselect: two-edge latency, then quiet drivers and masked STP
    csN = 1'b1; phyDirReq = 1'b1;
    edges(1);
    chk("R10", "dirOe after one edge", dirOe, 1'b1);
    edges(1);
    chk("R10", "dirOe after two edges", dirOe, 1'b0);
    stpIn = 1'b1; phyDirReq = 1'b0;
    edges(2);
    chk("R4", "nxtOe deselected", nxtOe, 1'b0);
    chk("R4", "dataOe deselected", dataOe, 1'b0);
    chk("R4", "stpQual deselected", stpQual, 1'b0);
    chk("R4", "STP ignored by pull-down", dataPullDn, 1'b0);
    chk("R9", "pll sticky after deselect", pllPwrReq, 1'b1);

    // Reselect with STP still high
    csN = 1'b0;
    edges(2);
    chk("R10", "dirOe back after two edges", dirOe, 1'b1);
    edges(1);
    chk("R6", "pull-down after reselect", dataPullDn, 1'b1);
    stpIn = 1'b0;

    // Reset while deselected: async DIR, PLL off
    csN = 1'b1;
    edges(3);
    rstN = 1'b0;
    #1;
    chk("R1", "async dirOut on reset", dirOut, 1'b1);
    edges(3);
    chk("R9", "pll off, reset while deselected", pllPwrReq, 1'b0);
    chk("R4", "dirOe deselected in reset", dirOe, 1'b0);
    rstN = 1'b1;
    edges(10);
    chk("R9", "pll stays off while deselected", pllPwrReq, 1'b0);
    chk("R3", "dirOut follows core after hold", dirOut, 1'b0);
    csN = 1'b0;
    edges(2);
    chk("R9", "pll on once selected", pllPwrReq, 1'b1);
    csN = 1'b1;
    edges(3);
    chk("R9", "pll latched after deselect", pllPwrReq, 1'b1);
    chk("R4", "dirOe off again", dirOe, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule